// File: doc/BRIEF.md
# Interrupt Destination Mask Generator

This block decides which of a set of local interrupt controllers must receive an interrupt message. A sender presents a command word, an 8-bit destination byte and its own controller index together with a one-cycle request strobe. The block samples the request and produces, one clock later, a bitmask with one bit per controller. Bit i set means controller i is a target.

Each controller contributes three configuration values, all taken as flat input vectors: an 8-bit physical ID, an 8-bit logical destination byte and a 4-bit destination-format nibble. Targets can be named in four ways. The first is a shorthand in the command word that selects the sender, every controller, or every controller except the sender. The second is a physical ID match, with a broadcast code. The third and fourth are logical matches under the flat model or the cluster model. When the command asks for lowest-priority delivery, the mask is cut down to a single candidate. The block does no real priority arbitration; that is left to whatever consumes the mask.

The configuration inputs are expected to stay stable from the request strobe until the mask has been consumed. Command bits other than the ones named below are ignored.

Top module: `irq_dest_mask_gen`

## Requirements
- R1: `mask_valid` is high in exactly the cycle after a cycle with `req_valid` high. While `mask_valid` is low, `mask` is all zeros.
- R2: The shorthand is `req_cmd[19:18]`. Code 0 selects targets by the destination byte, using the mode in R6 to R10.
- R3: Shorthand code 1 selects only the controller whose index equals `req_sender`.
- R4: Shorthand code 2 selects every controller.
- R5: Shorthand code 3 selects every controller except the one whose index equals `req_sender`.
- R6: `req_cmd[11]` chooses the mode: 0 is physical, 1 is logical. In physical mode a destination of 0xFF selects every controller.
- R7: In physical mode, any other destination selects the lowest-indexed controller whose physical ID equals the destination. If no ID matches, nothing is selected.
- R8: In logical mode, a controller whose format nibble is 0xF matches when the bitwise AND of the destination and its logical byte is nonzero.
- R9: In logical mode, a controller whose format nibble is 0x0 matches when the upper nibbles of the destination and its logical byte are equal and their lower nibbles share at least one set bit.
- R10: In logical mode, a controller whose format nibble is neither 0x0 nor 0xF never matches.
- R11: When `req_cmd[10:8]` equals 3'b001 (lowest priority), only the lowest-numbered set bit of the mask chosen under R2 to R10 is kept. An empty mask stays empty. Any other value of this field leaves the mask whole.
- R12: While `rst_n` is low, and in the first cycle after it rises, `mask_valid` and `mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_cmd | input | 32 | Command word: shorthand [19:18], mode [11], delivery type [10:8] |
| req_dest | input | 8 | Destination byte |
| req_sender | input | SEL_W | Index of the sending controller |
| cfg_phys_id | input | N_CTRL*8 | Physical ID of controller i in bits [8i+7:8i] |
| cfg_log_dest | input | N_CTRL*8 | Logical destination byte of controller i in bits [8i+7:8i] |
| cfg_fmt | input | N_CTRL*4 | Destination-format nibble of controller i in bits [4i+3:4i] |
| mask_valid | output | 1 | Mask is valid in this cycle |
| mask | output | N_CTRL | Target bitmask, bit i for controller i |

## Verification
The bound checker enforces the following on every cycle:
- the one-cycle lag from strobe to valid, and an all-zero mask while idle;
- the exact masks for the sender-only, all and all-but-sender shorthands;
- a full mask on physical broadcast;
- at most one target for a non-broadcast physical request or any lowest-priority request.

Several behaviours depend on the configured IDs, logical bytes and format nibbles, and only the bench scenarios can show them:
- which controller wins when physical IDs are duplicated;
- which controllers match under the flat and cluster models;
- that unknown formats never match;
- that the survivor of a lowest-priority reduction is the lowest index.

The bench compares these against a reference function, using both directed configurations and random ones.

// File: rtl/irq_dest_pkg.sv
// Package: irq_dest_pkg
// Shared constants and types for the interrupt destination mask generator.
// Command-word field positions are fixed because the sender's command
// format is decoded by several blocks; keep them in step with that format.
package irq_dest_pkg;

    localparam int ID_W        = 8;
    localparam int FMT_W       = 4;
    localparam int CMD_W       = 32;

    // Command-word field positions
    localparam int SH_LSB      = 18;
    localparam int MODE_BIT    = 11;
    localparam int DLV_LSB     = 8;

    localparam logic [ID_W-1:0]  BCAST_ID    = 8'hFF;
    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;
    localparam logic [2:0]       DLV_LOWEST  = 3'b001;

    typedef enum logic [1:0] {
        SH_ADDRESSED = 2'd0,
        SH_SELF      = 2'd1,
        SH_EVERYONE  = 2'd2,
        SH_OTHERS    = 2'd3
    } shorthand_e;

    typedef struct packed {
        shorthand_e       shorthand;
        logic             logical;
        logic             lowest;
        logic [ID_W-1:0]  dest;
    } dest_req_t;

endpackage

// File: rtl/irq_dest_req_reg.sv
// Module: irq_dest_req_reg
// Samples the sender's request on the strobe and holds the decoded fields
// until the next strobe. Also produces the one-cycle valid flag.
// Assumes: req_valid is a single-cycle pulse per request; synchronous
// active-low reset.
module irq_dest_req_reg
    import irq_dest_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CMD_W-1:0]     req_cmd,
    input  logic [ID_W-1:0]      req_dest,
    input  logic [SEL_W-1:0]     req_sender,
    output dest_req_t            held_req,
    output logic [SEL_W-1:0]     held_sender,
    output logic                 held_valid
);

    dest_req_t next_req;

    // Bits of the command word that play no part in target selection
    logic cmd_unused;
    assign cmd_unused = ^{req_cmd[CMD_W-1:SH_LSB+2],
                          req_cmd[SH_LSB-1:MODE_BIT+1],
                          req_cmd[DLV_LSB-1:0]};

    // Decode the command word into the held request fields
    always_comb begin
        next_req.shorthand = shorthand_e'(req_cmd[SH_LSB+1:SH_LSB]);
        next_req.logical   = req_cmd[MODE_BIT];
        next_req.lowest    = (req_cmd[DLV_LSB+2:DLV_LSB] == DLV_LOWEST);
        next_req.dest      = req_dest;
    end

    // Capture the request fields on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_req    <= '0;
            held_sender <= '0;
        end else if (req_valid) begin
            held_req    <= next_req;
            held_sender <= req_sender;
        end
    end

    // Valid follows the strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid <= 1'b0;
        end else begin
            held_valid <= req_valid;
        end
    end

endmodule

// File: rtl/irq_dest_match.sv
// Module: irq_dest_match
// Match logic for one controller. Compares the destination byte against
// that controller's physical ID and against its logical byte, using the
// controller's format nibble.
// Assumes: the configuration is stable while a request is held.
module irq_dest_match
    import irq_dest_pkg::*;
(
    input  logic [ID_W-1:0]  dest,
    input  logic [ID_W-1:0]  ctl_phys_id,
    input  logic [ID_W-1:0]  ctl_log_dest,
    input  logic [FMT_W-1:0] ctl_fmt,
    output logic             phys_hit,
    output logic             log_hit
);

    localparam int NIB = ID_W / 2;

    logic flat_hit;
    logic cluster_hit;

    // Physical comparison against the controller ID
    always_comb begin
        phys_hit = (dest == ctl_phys_id);
    end

    // Logical comparison under the flat and the cluster model
    always_comb begin
        flat_hit    = |(dest & ctl_log_dest);
        cluster_hit = (dest[ID_W-1:NIB] == ctl_log_dest[ID_W-1:NIB]) &&
                      (|(dest[NIB-1:0] & ctl_log_dest[NIB-1:0]));
    end

    // Choose the logical result by format; unknown formats never match
    always_comb begin
        unique case (ctl_fmt)
            FMT_FLAT:    log_hit = flat_hit;
            FMT_CLUSTER: log_hit = cluster_hit;
            default:     log_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_lowest_pick.sv
// Module: irq_lowest_pick
// Keeps only the lowest-numbered set bit of a vector; a zero vector stays
// zero. Pure combinational, built from a two's-complement isolate.
module irq_lowest_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] vec_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Isolate the least significant set bit
    always_comb begin
        vec_o = vec_i & ((~vec_i) + ONE);
    end

endmodule

// File: rtl/irq_dest_mask_gen.sv
// Module: irq_dest_mask_gen (top)
// Turns a held interrupt request into a per-controller target mask. The
// shorthand, physical or logical matching, and lowest-priority reduction
// are all applied here. The mask is valid one cycle after the strobe.
// Assumes: N_CTRL is between 2 and 256, configuration vectors are stable
// while a request is in flight, and req_sender < N_CTRL.
module irq_dest_mask_gen
    import irq_dest_pkg::*;
#(
    parameter int N_CTRL = 8,
    parameter int SEL_W  = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [CMD_W-1:0]          req_cmd,
    input  logic [ID_W-1:0]           req_dest,
    input  logic [SEL_W-1:0]          req_sender,
    input  logic [N_CTRL*ID_W-1:0]    cfg_phys_id,
    input  logic [N_CTRL*ID_W-1:0]    cfg_log_dest,
    input  logic [N_CTRL*FMT_W-1:0]   cfg_fmt,
    output logic                      mask_valid,
    output logic [N_CTRL-1:0]         mask
);

    dest_req_t           held_req;
    logic [SEL_W-1:0]    held_sender;
    logic                held_valid;

    logic [N_CTRL-1:0]   phys_hits;
    logic [N_CTRL-1:0]   phys_first;
    logic [N_CTRL-1:0]   log_hits;
    logic [N_CTRL-1:0]   self_vec;
    logic [N_CTRL-1:0]   phys_vec;
    logic [N_CTRL-1:0]   addr_vec;
    logic [N_CTRL-1:0]   chosen_vec;
    logic [N_CTRL-1:0]   single_vec;
    logic [N_CTRL-1:0]   final_vec;

    irq_dest_req_reg #(
        .SEL_W (SEL_W)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_dest    (req_dest),
        .req_sender  (req_sender),
        .held_req    (held_req),
        .held_sender (held_sender),
        .held_valid  (held_valid)
    );

    // One match slice and one sender-decode bit per controller
    for (genvar i = 0; i < N_CTRL; i++) begin : g_ctl
        irq_dest_match u_match (
            .dest         (held_req.dest),
            .ctl_phys_id  (cfg_phys_id[i*ID_W +: ID_W]),
            .ctl_log_dest (cfg_log_dest[i*ID_W +: ID_W]),
            .ctl_fmt      (cfg_fmt[i*FMT_W +: FMT_W]),
            .phys_hit     (phys_hits[i]),
            .log_hit      (log_hits[i])
        );

        // Decode the sender index to its own bit
        always_comb begin
            self_vec[i] = (held_sender == SEL_W'(i));
        end
    end

    // Duplicate physical IDs resolve to the lowest index
    irq_lowest_pick #(
        .W (N_CTRL)
    ) u_phys_pick (
        .vec_i (phys_hits),
        .vec_o (phys_first)
    );

    // Physical result: broadcast code or the single ID match
    always_comb begin
        phys_vec = (held_req.dest == BCAST_ID) ? {N_CTRL{1'b1}} : phys_first;
    end

    // Addressed result: logical or physical according to the mode bit
    always_comb begin
        addr_vec = held_req.logical ? log_hits : phys_vec;
    end

    // Apply the shorthand
    always_comb begin
        unique case (held_req.shorthand)
            SH_ADDRESSED: chosen_vec = addr_vec;
            SH_SELF:      chosen_vec = self_vec;
            SH_EVERYONE:  chosen_vec = {N_CTRL{1'b1}};
            SH_OTHERS:    chosen_vec = ~self_vec;
            default:      chosen_vec = '0;
        endcase
    end

    // Single-target reduction for lowest-priority delivery
    irq_lowest_pick #(
        .W (N_CTRL)
    ) u_single_pick (
        .vec_i (chosen_vec),
        .vec_o (single_vec)
    );

    // Select reduced or full mask
    always_comb begin
        final_vec = held_req.lowest ? single_vec : chosen_vec;
    end

    // Drive the outputs; the mask is forced to zero when not valid
    always_comb begin
        mask_valid = held_valid;
        mask       = held_valid ? final_vec : '0;
    end

endmodule

// File: rtl/irq_dest_mask_chk.sv
// Module: irq_dest_mask_chk
// Protocol and shape checks on the mask generator's ports, bound to every
// instance of the top module.
module irq_dest_mask_chk
    import irq_dest_pkg::*;
#(
    parameter int N_CTRL = 8,
    parameter int SEL_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CMD_W-1:0]     req_cmd,
    input  logic [ID_W-1:0]      req_dest,
    input  logic [SEL_W-1:0]     req_sender,
    input  logic                 mask_valid,
    input  logic [N_CTRL-1:0]    mask
);

    localparam logic [N_CTRL-1:0] ONE_HOT0 = {{(N_CTRL-1){1'b0}}, 1'b1};

    logic [1:0] sh_in;
    logic       low_in;
    assign sh_in  = req_cmd[SH_LSB+1:SH_LSB];
    assign low_in = (req_cmd[DLV_LSB+2:DLV_LSB] == DLV_LOWEST);

    p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mask_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !mask_valid);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_valid |-> (mask == '0));

    p_self_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh_in == 2'd1 && !low_in)
        |=> (mask == (ONE_HOT0 << $past(req_sender))));

    p_everyone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh_in == 2'd2 && !low_in) |=> (&mask));

    p_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh_in == 2'd3 && !low_in)
        |=> (!mask[$past(req_sender)] && $countones(mask) == N_CTRL - 1));

    p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh_in == 2'd0 && !req_cmd[MODE_BIT] &&
         req_dest == BCAST_ID && !low_in) |=> (&mask));

    p_phys_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh_in == 2'd0 && !req_cmd[MODE_BIT] &&
         req_dest != BCAST_ID) |=> $onehot0(mask));

    p_lowest_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && low_in) |=> $onehot0(mask));

endmodule

bind irq_dest_mask_gen irq_dest_mask_chk #(
    .N_CTRL (N_CTRL),
    .SEL_W  (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_dest   (req_dest),
    .req_sender (req_sender),
    .mask_valid (mask_valid),
    .mask       (mask)
);

// File: tb/test_irq_dest_mask_gen.sv
`timescale 1ns/1ps
module test_irq_dest_mask_gen;

    localparam int N  = 8;
    localparam int SW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [31:0]     req_cmd = '0;
    logic [7:0]      req_dest = '0;
    logic [SW-1:0]   req_sender = '0;
    logic [N*8-1:0]  cfg_phys_id;
    logic [N*8-1:0]  cfg_log_dest;
    logic [N*4-1:0]  cfg_fmt;
    logic            mask_valid;
    logic [N-1:0]    mask;

    logic [7:0] id_a  [N];
    logic [7:0] log_a [N];
    logic [3:0] fmt_a [N];

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cfg_phys_id[i*8 +: 8]  = id_a[i];
            cfg_log_dest[i*8 +: 8] = log_a[i];
            cfg_fmt[i*4 +: 4]      = fmt_a[i];
        end
    end

    irq_dest_mask_gen #(.N_CTRL(N)) i_irq_dest_mask_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .req_dest     (req_dest),
        .req_sender   (req_sender),
        .cfg_phys_id  (cfg_phys_id),
        .cfg_log_dest (cfg_log_dest),
        .cfg_fmt      (cfg_fmt),
        .mask_valid   (mask_valid),
        .mask         (mask)
    );

    task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Reference target mask from the requirements
    function automatic logic [N-1:0] model(logic [31:0] cmd, logic [7:0] d,
                                           logic [SW-1:0] snd);
        logic [N-1:0] m;
        logic [N-1:0] r;
        logic         found;
        m = '0;
        case (cmd[19:18])
            2'd1: m[snd] = 1'b1;
            2'd2: m = '1;
            2'd3: begin m = '1; m[snd] = 1'b0; end
            default: begin
                if (!cmd[11]) begin
                    if (d == 8'hFF) m = '1;
                    else begin
                        found = 1'b0;
                        for (int i = 0; i < N; i++)
                            if (!found && id_a[i] == d) begin
                                m[i] = 1'b1;
                                found = 1'b1;
                            end
                    end
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (fmt_a[i] == 4'hF)
                            m[i] = (d & log_a[i]) != 0;
                        else if (fmt_a[i] == 4'h0)
                            m[i] = (d[7:4] == log_a[i][7:4]) &&
                                   ((d[3:0] & log_a[i][3:0]) != 0);
                    end
                end
            end
        endcase
        if (cmd[10:8] == 3'b001) begin
            r = '0;
            for (int i = N - 1; i >= 0; i--)
                if (m[i]) r = '0 | (N'(1) << i);
            m = r;
        end
        return m;
    endfunction

    // Command word with junk in the bits that must be ignored
    function automatic logic [31:0] mk_cmd(logic [1:0] sh, logic lg, logic [2:0] dlv);
        logic [31:0] c;
        c = $urandom & 32'hFFF3_F0FF;
        c[19:18] = sh;
        c[11]    = lg;
        c[10:8]  = dlv;
        return c;
    endfunction

    task automatic send(string tag, logic [31:0] cmd, logic [7:0] d, logic [SW-1:0] snd);
        logic [N-1:0] exp;
        @(negedge clk);
        req_cmd    = cmd;
        req_dest   = d;
        req_sender = snd;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        req_cmd    = $urandom;
        req_dest   = 8'($urandom);
        exp = model(cmd, d, snd);
        check({tag, " R1 valid"}, {{(N-1){1'b0}}, mask_valid}, {{(N-1){1'b0}}, 1'b1});
        check(tag, mask, exp);
        @(negedge clk);
        check({tag, " R1 idle"}, mask, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            id_a[i]  = 8'(i * 3 + 1);
            log_a[i] = 8'(1 << i);
            fmt_a[i] = 4'hF;
        end
        repeat (3) @(negedge clk);
        check("R12 reset mask", mask, '0);
        check("R12 reset valid", {{(N-1){1'b0}}, mask_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", {mask[N-1:1], mask_valid}, '0);

        send("R3 self",        mk_cmd(2'd1, 1'b0, 3'd0), 8'h00, 3'd5);
        send("R4 everyone",    mk_cmd(2'd2, 1'b1, 3'd0), 8'h00, 3'd2);
        send("R5 others",      mk_cmd(2'd3, 1'b0, 3'd0), 8'h00, 3'd0);
        send("R5 others top",  mk_cmd(2'd3, 1'b0, 3'd4), 8'h00, 3'd7);
        send("R6 broadcast",   mk_cmd(2'd0, 1'b0, 3'd0), 8'hFF, 3'd1);
        send("R7 phys match",  mk_cmd(2'd0, 1'b0, 3'd0), 8'd13, 3'd1);
        send("R7 phys none",   mk_cmd(2'd0, 1'b0, 3'd0), 8'd2, 3'd1);
        id_a[6] = 8'd7; id_a[3] = 8'd7;
        send("R7 phys dup",    mk_cmd(2'd0, 1'b0, 3'd0), 8'd7, 3'd0);
        send("R8 flat",        mk_cmd(2'd0, 1'b1, 3'd0), 8'b1010_0101, 3'd0);
        send("R2 flat none",   mk_cmd(2'd0, 1'b1, 3'd0), 8'h00, 3'd0);
        for (int i = 0; i < N; i++) begin
            fmt_a[i] = 4'h0;
            log_a[i] = {4'(i / 4), 4'(1 << (i % 4))};
        end
        send("R9 cluster",     mk_cmd(2'd0, 1'b1, 3'd0), 8'h1B, 3'd0);
        send("R9 cluster miss",mk_cmd(2'd0, 1'b1, 3'd0), 8'h2F, 3'd0);
        fmt_a[1] = 4'h5; fmt_a[3] = 4'h8;
        send("R10 bad format", mk_cmd(2'd0, 1'b1, 3'd0), 8'h0F, 3'd0);
        send("R11 lowest all", mk_cmd(2'd2, 1'b0, 3'd1), 8'h00, 3'd0);
        send("R11 lowest oth", mk_cmd(2'd3, 1'b0, 3'd1), 8'h00, 3'd0);
        send("R11 lowest log", mk_cmd(2'd0, 1'b1, 3'd1), 8'h1C, 3'd0);
        send("R11 lowest empty", mk_cmd(2'd0, 1'b0, 3'd1), 8'd200, 3'd0);

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < N; i++) begin
                id_a[i]  = 8'($urandom_range(0, 15));
                log_a[i] = 8'($urandom);
                case ($urandom_range(0, 3))
                    0, 1:    fmt_a[i] = 4'hF;
                    2:       fmt_a[i] = 4'h0;
                    default: fmt_a[i] = 4'($urandom);
                endcase
            end
            send("R2 random",
                 mk_cmd(2'($urandom), 1'($urandom),
                        ($urandom_range(0, 1) == 1) ? 3'b001 : 3'($urandom)),
                 ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 31)),
                 SW'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule